// File: doc/BRIEF.md
# Decision Feedback Equalizer Loop

This block is the digital feedback equalizer of a sampled serial receiver. In each unit interval (one clock) it takes one signed digitized sample. It removes the post-cursor interference left by the symbols it has already decided, slices the corrected value into a binary decision and returns that decision to its own history.

The feedback path carries only past hard decisions, each mapped to an exact +1 or -1. Received noise therefore never enters the loop. The newest decision must weigh on the very next sample, so the path from decision to tap 1 to summing node to slicer has no pipeline stage. Tap weights come from a static weight bus. A bypass input zeroes every feedback term, which turns the block into a plain sign slicer for bring-up.

Pre-cursor interference, analog equalization, timing recovery and weight adaptation are handled elsewhere. A wrong decision is fed back like any other decision, so a short burst of follow-on errors is expected behaviour.

Top module: `dfe_loop`

## Requirements
- R1: One clock after a sample is presented, `corr_out` equals sample − Σ w_k·d_k over k = 1..4. Here d_k is +1 for a past decision of 1 and −1 for a past decision of 0. The value is a signed 12-bit two's-complement number.
- R2: One clock after a sample is presented, `dec_bit` is 1 when the corrected value is zero or positive, and 0 when it is negative.
- R3: The decision taken for sample n is the tap 1 term for sample n+1, with no extra cycle of latency.
- R4: Tap k uses the decision taken k samples earlier. Its weight is the signed 8-bit field `weights[8k-1 : 8k-8]`.
- R5: A synchronous active-high reset clears `dec_bit`, `corr_out` and `dec_valid` to 0 and sets all four history entries to −1.
- R6: After reset, `dec_valid` is 0 for the results of the first four samples. It is 1 from the result of the fifth sample on, until the next reset.
- R7: While `bypass` is 1, every feedback term is zero, so `corr_out` equals the sign-extended sample. Decisions still enter the history, so the first sample after bypass ends uses the decisions taken during bypass.
- R8: The corrected value never wraps. Extreme inputs give −640 for sample −128 with all weights −128 and history −1. They give +639 for sample 127 with all weights −128 and history +1. They give −636 for sample −128 with all weights 127 and history +1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock, one sample per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sample | input | 8 | Signed digitized sample for the current unit interval |
| weights | input | 32 | Four signed 8-bit tap weights, tap 1 in the low byte |
| bypass | input | 1 | 1 forces all feedback terms to zero |
| dec_bit | output | 1 | Registered decision for the last sample |
| corr_out | output | 12 | Registered signed corrected value at the summing node |
| dec_valid | output | 1 | Decision history fully populated since reset |

## Verification
The bench targets the zero-valued corrected sample. A slicer that treats zero as negative would return 0 there instead of 1. The extreme sample and weight combinations are driven as well, and a summing node that is too narrow would wrap to the wrong sign. Single-tap weight patterns expose swapped tap ordering and an extra cycle in the tap 1 loop, either of which shifts the cancelled interference by one symbol. The bench also checks the transition out of bypass and a reset in mid-run. The valid flag must rise exactly on the fifth result, and the first post-bypass sample must see the decisions taken while bypass was active.

// File: rtl/dfe_pkg.sv
package dfe_pkg;

    localparam int SAMPLE_W = 8;
    localparam int WEIGHT_W = 8;
    localparam int NTAPS    = 4;

    // Width that holds sample minus NTAPS full-scale terms without wrap
    function automatic int acc_width(input int sw, input int ww, input int n);
        return ((sw > ww) ? sw : ww) + $clog2(n + 1) + 1;
    endfunction

    localparam int ACC_W = acc_width(SAMPLE_W, WEIGHT_W, NTAPS);

    // Registered slicer result
    typedef struct packed {
        logic valid;
        logic dec;
    } slice_flags_t;

endpackage

// File: rtl/dfe_history.sv
module dfe_history #(
    parameter int NTAPS = dfe_pkg::NTAPS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             d_in,
    output logic [NTAPS-1:0] hist   // hist[k-1] is the decision k symbols back; 1 = +1
);

    generate
        if (NTAPS == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) hist <= '0;
                else     hist <= d_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) hist <= '0;
                else     hist <= {hist[NTAPS-2:0], d_in};
            end
            for (genvar k = 1; k < NTAPS; k++) begin : g_chk
                AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (rst)
                    !$past(rst) |-> hist[k] == $past(hist[k-1])); // R4
            end
        end
    endgenerate

endmodule

// File: rtl/dfe_feedback.sv
module dfe_feedback #(
    parameter int NTAPS    = dfe_pkg::NTAPS,
    parameter int WEIGHT_W = dfe_pkg::WEIGHT_W,
    parameter int ACC_W    = dfe_pkg::ACC_W
) (
    input  logic [NTAPS*WEIGHT_W-1:0] weights,
    input  logic [NTAPS-1:0]          hist,
    input  logic                      bypass,
    output logic signed [ACC_W-1:0]   fb
);

    localparam int LIMIT = NTAPS * (2 ** (WEIGHT_W - 1));

    logic signed [ACC_W-1:0] term [NTAPS];

    generate
        for (genvar k = 0; k < NTAPS; k++) begin : g_tap
            logic signed [ACC_W-1:0] w_ext;
            assign w_ext = ACC_W'($signed(weights[k*WEIGHT_W +: WEIGHT_W]));
            always_comb begin
                if (bypass)       term[k] = '0;
                else if (hist[k]) term[k] = w_ext;
                else              term[k] = -w_ext;
            end
        end
    endgenerate

    always_comb begin
        fb = '0;
        for (int k = 0; k < NTAPS; k++) fb = fb + term[k];
    end

    always_comb begin
        AST_NO_OVERFLOW: assert (fb <= ACC_W'(LIMIT) && fb >= -ACC_W'(LIMIT)); // R8
    end

endmodule

// File: rtl/dfe_slicer.sv
module dfe_slicer #(
    parameter int NTAPS = dfe_pkg::NTAPS,
    parameter int ACC_W = dfe_pkg::ACC_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [ACC_W-1:0] corr,
    output logic                    dec_now,
    output logic                    dec_q,
    output logic signed [ACC_W-1:0] corr_q,
    output logic                    valid_q
);

    localparam int CNT_W = $clog2(NTAPS + 1);

    logic [CNT_W-1:0]      seen;
    dfe_pkg::slice_flags_t flags;

    assign dec_now = (corr >= 0);

    always_ff @(posedge clk) begin
        if (rst) begin
            seen   <= '0;
            flags  <= '0;
            corr_q <= '0;
        end else begin
            if (seen != CNT_W'(NTAPS)) seen <= seen + 1'b1;
            flags.valid <= (seen == CNT_W'(NTAPS));
            flags.dec   <= dec_now;
            corr_q      <= corr;
        end
    end

    assign dec_q   = flags.dec;
    assign valid_q = flags.valid;

    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> valid_q); // R6

endmodule

// File: rtl/dfe_loop.sv
module dfe_loop #(
    parameter int SAMPLE_W = dfe_pkg::SAMPLE_W,
    parameter int WEIGHT_W = dfe_pkg::WEIGHT_W,
    parameter int NTAPS    = dfe_pkg::NTAPS,
    localparam int ACC_W   = dfe_pkg::acc_width(SAMPLE_W, WEIGHT_W, NTAPS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [SAMPLE_W-1:0]       sample,
    input  logic [NTAPS*WEIGHT_W-1:0] weights,
    input  logic                      bypass,
    output logic                      dec_bit,
    output logic [ACC_W-1:0]          corr_out,
    output logic                      dec_valid
);

    logic [NTAPS-1:0]        hist;
    logic signed [ACC_W-1:0] fb;
    logic signed [ACC_W-1:0] s_ext;
    logic signed [ACC_W-1:0] corr;
    logic signed [ACC_W-1:0] corr_q;
    logic                    dec_now;

    assign s_ext = ACC_W'($signed(sample));
    assign corr  = s_ext - fb;

    dfe_feedback #(.NTAPS(NTAPS), .WEIGHT_W(WEIGHT_W), .ACC_W(ACC_W)) u_fb (
        .weights (weights),
        .hist    (hist),
        .bypass  (bypass),
        .fb      (fb)
    );

    dfe_slicer #(.NTAPS(NTAPS), .ACC_W(ACC_W)) u_slc (
        .clk     (clk),
        .rst     (rst),
        .corr    (corr),
        .dec_now (dec_now),
        .dec_q   (dec_bit),
        .corr_q  (corr_q),
        .valid_q (dec_valid)
    );

    dfe_history #(.NTAPS(NTAPS)) u_hist (
        .clk  (clk),
        .rst  (rst),
        .d_in (dec_now),
        .hist (hist)
    );

    assign corr_out = corr_q;

    AST_TAP1_FEED: assert property (@(posedge clk) disable iff (rst)
        hist[0] == dec_bit); // R3

    AST_BYPASS_PLAIN: assert property (@(posedge clk) disable iff (rst)
        bypass |=> $signed(corr_out) == ACC_W'($signed($past(sample)))); // R7

endmodule

// File: tb/sim_dfe_loop.sv
module sim_dfe_loop;

    localparam int N = 4;

    logic        clk = 0;
    logic        rst = 1;
    logic [7:0]  sample = '0;
    logic [31:0] weights = '0;
    logic        bypass = 0;
    logic        dec_bit;
    logic [11:0] corr_out;
    logic        dec_valid;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    int wt [N];
    int hk [N];   // model history, +1/-1, hk[0] is one symbol back
    int idx;

    always #2.5 clk = ~clk;   // 200 MHz

    dfe_loop u0 (
        .clk(clk), .rst(rst), .sample(sample), .weights(weights),
        .bypass(bypass), .dec_bit(dec_bit), .corr_out(corr_out),
        .dec_valid(dec_valid)
    );

    task automatic chk(input int act, input int exp, input string tag);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic set_w(input int a, input int b, input int c, input int d);
        wt[0] = a; wt[1] = b; wt[2] = c; wt[3] = d;
        for (int k = 0; k < N; k++) weights[k*8 +: 8] = 8'(wt[k]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        @(posedge clk); @(negedge clk);
        chk(int'(dec_bit),   0, "R5 dec");
        chk(int'($signed(corr_out)), 0, "R5 corr");
        chk(int'(dec_valid), 0, "R5 valid");
        rst = 0;
        for (int k = 0; k < N; k++) hk[k] = -1;
        idx = 0;
    endtask

    // called at a negedge: drive one sample, check the result one edge later
    task automatic step(input int s, input bit byp, input string tag);
        int ec; int ed; int ev;
        sample = 8'(s);
        bypass = byp;
        ec = s;
        if (!byp) for (int k = 0; k < N; k++) ec -= wt[k] * hk[k];
        ed = (ec >= 0) ? 1 : 0;
        ev = (idx >= N) ? 1 : 0;
        @(posedge clk); @(negedge clk);
        chk(int'($signed(corr_out)), ec, {tag, " R1 corr"});
        chk(int'(dec_bit), ed, {tag, " R2 dec"});
        chk(int'(dec_valid), ev, {tag, " R6 valid"});
        for (int k = N - 1; k > 0; k--) hk[k] = hk[k-1];
        hk[0] = ed ? 1 : -1;
        idx++;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 1234;
        void'($urandom(seed));
        set_w(0, 0, 0, 0);
        repeat (2) @(posedge clk);
        do_reset();

        // R2: zero corrected value slices to 1; R6 first samples invalid
        step(0, 0, "R2 zero");
        step(-1, 0, "R2 neg");
        // R3: tap1 only, back-to-back feedback
        set_w(100, 0, 0, 0);
        step(50, 0, "R3 a");
        step(50, 0, "R3 b");
        step(-20, 0, "R3 c");
        step(120, 0, "R3 d");
        // R4: only tap 4 active, pattern reveals ordering
        set_w(0, 0, 0, 20);
        step(50, 0, "R4 a");
        step(-50, 0, "R4 b");
        step(-50, 0, "R4 c");
        step(-50, 0, "R4 d");
        step(10, 0, "R4 e");
        step(-10, 0, "R4 f");
        set_w(0, 0, 30, 0);
        step(25, 0, "R4 g");
        step(-25, 0, "R4 h");
        step(0, 0, "R4 i");
        // R7: bypass passes sample, history keeps updating
        set_w(60, -40, 25, -10);
        step(-5, 1, "R7 a");
        step(7, 1, "R7 b");
        step(-100, 1, "R7 c");
        step(3, 0, "R7 exit");
        // R8 extremes
        set_w(127, 127, 127, 127);
        repeat (N) step(127, 1, "R8 load+");
        step(-128, 0, "R8 min-636");
        set_w(-128, -128, -128, -128);
        repeat (N) step(127, 1, "R8 load+");
        step(127, 0, "R8 max639");
        repeat (N) step(-128, 1, "R8 load-");
        step(-128, 0, "R8 min-640");

        // R5 mid-run reset and R6 valid timing again
        do_reset();
        set_w(10, -5, 3, 1);
        for (int i = 0; i < 8; i++) step(i * 7 - 20, 0, "R6 rerun");

        // random phase
        for (int blk = 0; blk < 8; blk++) begin
            set_w(int'($signed(8'($urandom))), int'($signed(8'($urandom))),
                  int'($signed(8'($urandom))), int'($signed(8'($urandom))));
            for (int i = 0; i < 60; i++)
                step(int'($signed(8'($urandom))), ($urandom % 10) == 0, "rand R4");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule